// File: doc/BRIEF.md
# System Clock Control Unit

This block holds two byte-wide clock control registers behind a simple register bus and turns them into the clock controls of a small processor. The CPU system clock is taken either from the main oscillator or from the sub-clock oscillator. On the main path it is divided by 1, 2, 4, 8 or 16. A single override bit forces the ratio to 8 whatever the second register's divider field holds. Each oscillator appears as a one-cycle tick input on the block's reference clock. Every derived clock leaves as a one-cycle enable pulse, so the surrounding logic stays on one clock.

The block also picks the source for the clock-output pin. It gates the peripheral clock during wait mode, and it handles stop mode. When stop mode is entered while the main oscillator drives the system clock, the block forces the divide-by-8 bit and the main-drive bit to 1. When it is entered while the sub-clock drives the system clock, those bits keep their values. A wake-up interrupt input ends stop mode. Register writes take effect only while the external protect input is high.

A three-state machine follows the operating mode. The states are `MODE_HIGH` (main oscillator source) and `MODE_LOW` (sub-clock source), which are the running modes, and `MODE_STOP` (all clocks halted). The transitions are:
- `MODE_HIGH` to `MODE_LOW` when the source bit becomes 1.
- `MODE_LOW` to `MODE_HIGH` when the source bit becomes 0.
- `MODE_HIGH` or `MODE_LOW` to `MODE_STOP` when the stop bit becomes 1.
- `MODE_STOP` back to `MODE_HIGH` or `MODE_LOW`, chosen by the source bit, when the stop bit is cleared by a wake-up or by a write.

Top module: `sysclk_ctrl`

## Requirements
- R1: After reset, control register A (bus_addr 0) reads 0x48, control register B (bus_addr 1) reads 0x20, and stop_mode is 0.
- R2: A write while prot_en is 0 leaves both registers unchanged.
- R3: Bits [4:1] of register B always read 0, whatever value is written there.
- R4: The main-path divide ratio is 8 when register A bit 6 is 1. Otherwise register B bits [7:6] set it: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 16. In MODE_HIGH, sys_tick pulses on every ratio-th live main tick.
- R5: When the ratio changes, the divider restarts. With main_tick held high, the first sys_tick comes in the ratio-th cycle after the write edge, counting the first cycle after that edge as cycle 1.
- R6: When register A bit 7 is 1 (MODE_LOW), sys_tick follows sub_tick, gated by the sub-clock enable in register A bit 4. When bit 7 is 0, sys_tick comes from the main divider.
- R7: If one write to register A changes both bit 4 and bit 7, bit 7 keeps its old value and the other bits take the written value.
- R8: main_osc_stop is high when register A bit 5 is 1 or in stop mode. sub_osc_en equals register A bit 4 outside stop mode and is 0 in stop mode.
- R9: Register A bits [1:0] pick the clock-output pin: 00 is the plain port (clkout_en 0, no ticks), 01 gives the live sub-clock, 10 gives main divided by 8 and 11 gives main divided by 32.
- R10: Writing register B bit 0 as 1 enters stop mode in the next cycle. In stop mode, sys_tick, periph_tick, clkout_tick and sub32_tick are all 0.
- R11: On stop entry from MODE_HIGH, register A bit 6 and register B bit 5 are forced to 1. On stop entry from MODE_LOW, both keep their values.
- R12: When wait_mode is 1 and register A bit 2 is 1, periph_tick is held at 0. sub32_tick, one pulse per 32 live sub ticks, is not affected.
- R13: wake_irq clears register B bit 0 and leaves stop mode. When wake_irq and a write to register B come in the same cycle, the wake-up wins over the written bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 is register A, 1 is register B |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| prot_en | input | 1 | Write-enable protect bit |
| wake_irq | input | 1 | Wake-up interrupt, ends stop mode |
| wait_mode | input | 1 | CPU is in wait mode |
| main_tick | input | 1 | One pulse per main oscillator cycle |
| sub_tick | input | 1 | One pulse per sub-clock cycle |
| sys_tick | output | 1 | System clock enable pulse |
| periph_tick | output | 1 | Undivided main peripheral clock pulse |
| sub32_tick | output | 1 | Sub-clock divided by 32 pulse |
| clkout_en | output | 1 | Clock-output pin function is active |
| clkout_tick | output | 1 | Clock-output pin pulse |
| main_osc_stop | output | 1 | Request to stop the main oscillator |
| sub_osc_en | output | 1 | Sub-clock pins and oscillator enabled |
| stop_mode | output | 1 | Stop mode is active |

## Verification
The assertions take for granted that tick inputs are clean single-cycle pulses in the reference clock domain. They also assume that prot_en stays low across any cycle in which register A must not change, since a protected cycle allows no write at all. The bench drives every input half a cycle away from the active edge. It keeps main_tick high through each divider window, so the restart rule gives exact pulse positions. It changes the divide ratio on every write in the divider sequence, because a rewrite of the same ratio does not restart the counter. Single-cycle wake pulses are used, including one that coincides with a register B write.

// File: rtl/sysclk_pkg.sv
`timescale 1ns/1ps
package sysclk_pkg;

    typedef enum logic [1:0] {
        MODE_HIGH = 2'd0,
        MODE_LOW  = 2'd1,
        MODE_STOP = 2'd2
    } clk_mode_e;

    // bit positions of register A
    localparam int A_OSEL_LO  = 0;
    localparam int A_WAITGATE = 2;
    localparam int A_SUBEN    = 4;
    localparam int A_MAINOFF  = 5;
    localparam int A_DIV8     = 6;
    localparam int A_SRC      = 7;
    // bit positions of register B
    localparam int B_STOP     = 0;
    localparam int B_MAINDRV  = 5;
    localparam int B_DIV_LO   = 6;

    localparam logic [7:0] A_RESET    = 8'h48;
    localparam logic [7:0] B_RESET    = 8'h20;
    localparam logic [7:0] B_RSV_MASK = 8'h1E;

    localparam int DIV_MAX   = 16;
    localparam int DIV_CNT_W = $clog2(DIV_MAX);

    function automatic logic [DIV_CNT_W:0] div_ratio(input logic force8,
                                                    input logic [1:0] code);
        logic [DIV_CNT_W:0] r;
        if (force8) begin
            r = (DIV_CNT_W+1)'(8);
        end else begin
            unique case (code)
                2'b00:   r = (DIV_CNT_W+1)'(1);
                2'b01:   r = (DIV_CNT_W+1)'(2);
                2'b10:   r = (DIV_CNT_W+1)'(4);
                default: r = (DIV_CNT_W+1)'(DIV_MAX);
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/sysclk_regs.sv
`timescale 1ns/1ps
module sysclk_regs
    import sysclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    input  logic       prot_en,
    input  logic       wake_irq,
    input  clk_mode_e  mode_q,
    output logic [7:0] rega_q,
    output logic [7:0] regb_q,
    output logic       stop_nx,
    output logic       src_nx
);

    logic [7:0] rega_d;
    logic [7:0] regb_d;
    logic       wr_ok;
    logic       both_flip;
    logic       stop_entry;

    always_comb begin
        rega_d     = rega_q;
        regb_d     = regb_q;
        wr_ok      = wr_en & prot_en;
        both_flip  = (wr_data[A_SUBEN] != rega_q[A_SUBEN]) &&
                     (wr_data[A_SRC]   != rega_q[A_SRC]);
        stop_entry = 1'b0;

        if (wr_ok && !wr_addr) begin
            rega_d = wr_data;
            if (both_flip) begin
                rega_d[A_SRC] = rega_q[A_SRC];
            end
        end

        if (wr_ok && wr_addr) begin
            regb_d     = wr_data & ~B_RSV_MASK;
            stop_entry = wr_data[B_STOP] && !regb_q[B_STOP] && !wake_irq;
            if (stop_entry && (mode_q == MODE_HIGH)) begin
                rega_d[A_DIV8]    = 1'b1;
                regb_d[B_MAINDRV] = 1'b1;
            end
        end

        if (wake_irq) begin
            regb_d[B_STOP] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rega_q <= A_RESET;
            regb_q <= B_RESET;
        end else begin
            rega_q <= rega_d;
            regb_q <= regb_d;
        end
    end

    assign stop_nx = regb_d[B_STOP];
    assign src_nx  = rega_d[A_SRC];

endmodule

// File: rtl/sysclk_mode_fsm.sv
`timescale 1ns/1ps
module sysclk_mode_fsm
    import sysclk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stop_nx,
    input  logic      src_nx,
    output clk_mode_e mode_q,
    output logic      run_main,
    output logic      run_sub,
    output logic      halted
);

    clk_mode_e mode_d;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_HIGH: begin
                if (stop_nx)     mode_d = MODE_STOP;
                else if (src_nx) mode_d = MODE_LOW;
            end
            MODE_LOW: begin
                if (stop_nx)      mode_d = MODE_STOP;
                else if (!src_nx) mode_d = MODE_HIGH;
            end
            MODE_STOP: begin
                if (!stop_nx) mode_d = src_nx ? MODE_LOW : MODE_HIGH;
            end
            default: mode_d = MODE_HIGH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_HIGH;
        else        mode_q <= mode_d;
    end

    always_comb begin
        run_main = 1'b0;
        run_sub  = 1'b0;
        halted   = 1'b0;
        unique case (mode_q)
            MODE_HIGH: run_main = 1'b1;
            MODE_LOW:  run_sub  = 1'b1;
            MODE_STOP: halted   = 1'b1;
            default:   halted   = 1'b1;
        endcase
    end

endmodule

// File: rtl/sysclk_divider.sv
`timescale 1ns/1ps
module sysclk_divider #(
    parameter int CNT_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_in,
    input  logic [CNT_W:0] ratio,
    output logic           tick_out
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_eff;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W:0]   ratio_q;
    logic             restart;

    always_comb begin
        restart  = (ratio != ratio_q);
        cnt_eff  = restart ? '0 : cnt_q;
        tick_out = tick_in && ({1'b0, cnt_eff} == (ratio - 1'b1));
        if (tick_out)     cnt_d = '0;
        else if (tick_in) cnt_d = cnt_eff + 1'b1;
        else              cnt_d = cnt_eff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ratio_q <= '0;
        end else begin
            cnt_q   <= cnt_d;
            ratio_q <= ratio;
        end
    end

endmodule

// File: rtl/sysclk_prescale.sv
`timescale 1ns/1ps
module sysclk_prescale #(
    parameter int W = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    output logic tick_out
);

    logic [W-1:0] cnt_q;

    assign tick_out = tick_in && (&cnt_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (tick_in) cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/sysclk_outmux.sv
`timescale 1ns/1ps
module sysclk_outmux (
    input  logic [1:0] sel,
    input  logic       f_sub,
    input  logic       f_by8,
    input  logic       f_by32,
    output logic       pin_en,
    output logic       pin_tick
);

    always_comb begin
        pin_en   = 1'b1;
        pin_tick = 1'b0;
        unique case (sel)
            2'b00: pin_en   = 1'b0;
            2'b01: pin_tick = f_sub;
            2'b10: pin_tick = f_by8;
            2'b11: pin_tick = f_by32;
            default: pin_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/sysclk_ctrl.sv
`timescale 1ns/1ps
module sysclk_ctrl
    import sysclk_pkg::*;
#(
    parameter int OUT_SLOW_W = 3,
    parameter int OUT_SLOWER_W = 5,
    parameter int SUB_SLOW_W = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       prot_en,
    input  logic       wake_irq,
    input  logic       wait_mode,
    input  logic       main_tick,
    input  logic       sub_tick,
    output logic       sys_tick,
    output logic       periph_tick,
    output logic       sub32_tick,
    output logic       clkout_en,
    output logic       clkout_tick,
    output logic       main_osc_stop,
    output logic       sub_osc_en,
    output logic       stop_mode
);

    logic [7:0]         ctl0_q;
    logic [7:0]         ctl1_q;
    logic               stop_nx;
    logic               src_nx;
    clk_mode_e          mode_q;
    logic               run_main;
    logic               run_sub;
    logic               halted;
    logic               main_live;
    logic               sub_live;
    logic               main_div;
    logic               f_by8;
    logic               f_by32;
    logic [DIV_CNT_W:0] ratio;

    sysclk_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .wr_addr  (bus_addr),
        .wr_data  (bus_wdata),
        .prot_en  (prot_en),
        .wake_irq (wake_irq),
        .mode_q   (mode_q),
        .rega_q   (ctl0_q),
        .regb_q   (ctl1_q),
        .stop_nx  (stop_nx),
        .src_nx   (src_nx)
    );

    sysclk_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop_nx  (stop_nx),
        .src_nx   (src_nx),
        .mode_q   (mode_q),
        .run_main (run_main),
        .run_sub  (run_sub),
        .halted   (halted)
    );

    assign main_live = main_tick & ~ctl0_q[A_MAINOFF] & ~halted;
    assign sub_live  = sub_tick  &  ctl0_q[A_SUBEN]   & ~halted;
    assign ratio     = div_ratio(ctl0_q[A_DIV8], ctl1_q[B_DIV_LO +: 2]);

    sysclk_divider #(.CNT_W(DIV_CNT_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_in  (main_live),
        .ratio    (ratio),
        .tick_out (main_div)
    );

    sysclk_prescale #(.W(OUT_SLOW_W)) u_by8 (
        .clk (clk), .rst_n (rst_n), .tick_in (main_live), .tick_out (f_by8)
    );

    sysclk_prescale #(.W(OUT_SLOWER_W)) u_by32 (
        .clk (clk), .rst_n (rst_n), .tick_in (main_live), .tick_out (f_by32)
    );

    sysclk_prescale #(.W(SUB_SLOW_W)) u_sub32 (
        .clk (clk), .rst_n (rst_n), .tick_in (sub_live), .tick_out (sub32_tick)
    );

    sysclk_outmux u_omux (
        .sel      (ctl0_q[A_OSEL_LO +: 2]),
        .f_sub    (sub_live),
        .f_by8    (f_by8),
        .f_by32   (f_by32),
        .pin_en   (clkout_en),
        .pin_tick (clkout_tick)
    );

    assign sys_tick      = (run_main & main_div) | (run_sub & sub_live);
    assign periph_tick   = main_live & ~(wait_mode & ctl0_q[A_WAITGATE]);
    assign main_osc_stop = ctl0_q[A_MAINOFF] | halted;
    assign sub_osc_en    = ctl0_q[A_SUBEN] & ~halted;
    assign stop_mode     = halted;
    assign bus_rdata     = bus_addr ? ctl1_q : ctl0_q;

endmodule

// File: rtl/sysclk_chk.sv
`timescale 1ns/1ps
module sysclk_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       prot_en,
    input logic       wake_irq,
    input logic       stop_mode,
    input logic       sys_tick,
    input logic       periph_tick,
    input logic       sub32_tick,
    input logic       clkout_en,
    input logic       clkout_tick,
    input logic       main_osc_stop,
    input logic       sub_osc_en,
    input logic [7:0] ctl0
);

    // R2
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_en |=> $stable(ctl0));

    // R10
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_mode |-> !sys_tick && !periph_tick && !clkout_tick && !sub32_tick);

    // R8
    stop_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_mode |-> main_osc_stop && !sub_osc_en);

    // R13
    wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |=> !stop_mode);

    // R9
    pin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clkout_en |-> !clkout_tick);

endmodule

bind sysclk_ctrl sysclk_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .prot_en       (prot_en),
    .wake_irq      (wake_irq),
    .stop_mode     (stop_mode),
    .sys_tick      (sys_tick),
    .periph_tick   (periph_tick),
    .sub32_tick    (sub32_tick),
    .clkout_en     (clkout_en),
    .clkout_tick   (clkout_tick),
    .main_osc_stop (main_osc_stop),
    .sub_osc_en    (sub_osc_en),
    .ctl0          (ctl0_q)
);

// File: tb/sim_sysclk_ctrl.sv
`timescale 1ns/1ps
module sim_sysclk_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       prot_en = 1'b1;
    logic       wake_irq = 1'b0;
    logic       wait_mode = 1'b0;
    logic       main_tick = 1'b1;
    logic       sub_tick = 1'b0;
    logic       sys_tick, periph_tick, sub32_tick, clkout_en, clkout_tick;
    logic       main_osc_stop, sub_osc_en, stop_mode;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    bit  exp_q[$];

    always #4 clk = ~clk;

    sysclk_ctrl u0 (
        .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .prot_en (prot_en),
        .wake_irq (wake_irq), .wait_mode (wait_mode), .main_tick (main_tick),
        .sub_tick (sub_tick), .sys_tick (sys_tick), .periph_tick (periph_tick),
        .sub32_tick (sub32_tick), .clkout_en (clkout_en), .clkout_tick (clkout_tick),
        .main_osc_stop (main_osc_stop), .sub_osc_en (sub_osc_en), .stop_mode (stop_mode)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    // driver side of the scoreboard: expected sys_tick for the next n cycles
    task automatic push_div(input int ratio, input int n);
        for (int k = 1; k <= n; k++) exp_q.push_back((k % ratio) == 0);
    endtask

    task automatic drain;
        wait (exp_q.size() == 0);
    endtask

    task automatic count_ticks(input int cycles, input bit pick_sub32, output int cnt);
        cnt = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk); #2;
            if (pick_sub32 ? sub32_tick : clkout_tick) cnt++;
        end
    endtask

    // monitor side of the scoreboard
    initial begin
        forever begin
            @(negedge clk); #2;
            if (exp_q.size() > 0) begin
                bit e;
                e = exp_q.pop_front();
                chk("R4 R5 sys_tick stream", {7'd0, sys_tick}, {7'd0, e});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        // R1 reset state
        rd_chk("R1 reg A reset", 1'b0, 8'h48);
        rd_chk("R1 reg B reset", 1'b1, 8'h20);
        chk("R1 stop_mode reset", {7'd0, stop_mode}, 8'h00);

        // R2 protect
        prot_en = 1'b0;
        wr(1'b0, 8'h00);
        prot_en = 1'b1;
        #2; rd_chk("R2 locked write", 1'b0, 8'h48);

        // R3 reserved bits
        wr(1'b1, 8'hFE);
        #2; rd_chk("R3 reserved zero", 1'b1, 8'hE0);

        // R4 R5 divider sequence
        wr(1'b0, 8'h08); push_div(16, 40); drain();
        wr(1'b1, 8'h20); push_div(1, 8);   drain();
        wr(1'b1, 8'h60); push_div(2, 12);  drain();
        wr(1'b1, 8'hA0); push_div(4, 16);  drain();
        wr(1'b0, 8'h48); push_div(8, 24);  drain();

        // R7 enable and source flip in one write
        wr(1'b0, 8'h98);
        #2; rd_chk("R7 source held", 1'b0, 8'h18);

        // R6 sub source
        wr(1'b0, 8'h98);
        #2; rd_chk("R6 source set", 1'b0, 8'h98);
        chk("R8 sub_osc_en", {7'd0, sub_osc_en}, 8'h01);
        @(negedge clk); main_tick = 1'b0; sub_tick = 1'b1; #2;
        chk("R6 sys from sub high", {7'd0, sys_tick}, 8'h01);
        @(negedge clk); sub_tick = 1'b0; main_tick = 1'b1; #2;
        chk("R6 sys from sub low", {7'd0, sys_tick}, 8'h00);

        // R8 main stop request
        wr(1'b0, 8'hB8);
        #2; chk("R8 main_osc_stop", {7'd0, main_osc_stop}, 8'h01);
        sub_tick = 1'b1;

        // R10 R11 stop entry from low speed
        wr(1'b1, 8'h41);
        #2;
        chk("R10 stop_mode", {7'd0, stop_mode}, 8'h01);
        chk("R10 ticks quiet", {4'd0, sys_tick, periph_tick, clkout_tick, sub32_tick}, 8'h00);
        chk("R8 stop osc", {6'd0, main_osc_stop, sub_osc_en}, 8'h02);
        rd_chk("R11 low keeps A", 1'b0, 8'hB8);
        rd_chk("R11 low keeps B", 1'b1, 8'h41);

        // R13 wake
        @(negedge clk); wake_irq = 1'b1;
        @(negedge clk); wake_irq = 1'b0; #2;
        chk("R13 wake exits", {7'd0, stop_mode}, 8'h00);
        rd_chk("R13 stop bit cleared", 1'b1, 8'h40);

        // R11 stop entry from high speed
        wr(1'b0, 8'h18);
        wr(1'b1, 8'h41);
        #2;
        chk("R10 stop from high", {7'd0, stop_mode}, 8'h01);
        rd_chk("R11 high forces A", 1'b0, 8'h58);
        rd_chk("R11 high forces B", 1'b1, 8'h61);

        // R13 wake together with write
        @(negedge clk);
        wake_irq = 1'b1; bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 8'h61;
        @(negedge clk);
        wake_irq = 1'b0; bus_wr = 1'b0; #2;
        chk("R13 wake beats write", {7'd0, stop_mode}, 8'h00);
        rd_chk("R13 reg B after clash", 1'b1, 8'h60);

        // R9 clock-output pin
        wr(1'b0, 8'h59);
        @(negedge clk); sub_tick = 1'b1; #2;
        chk("R9 pin sub high", {6'd0, clkout_en, clkout_tick}, 8'h03);
        @(negedge clk); sub_tick = 1'b0; #2;
        chk("R9 pin sub low", {6'd0, clkout_en, clkout_tick}, 8'h02);
        wr(1'b0, 8'h5A);
        count_ticks(64, 1'b0, cnt);
        chk("R9 pin div8 count", 8'(cnt), 8'd8);
        wr(1'b0, 8'h5B);
        count_ticks(64, 1'b0, cnt);
        chk("R9 pin div32 count", 8'(cnt), 8'd2);
        wr(1'b0, 8'h58);
        #2; chk("R9 pin port", {6'd0, clkout_en, clkout_tick}, 8'h00);

        // R12 wait gating
        wr(1'b0, 8'h5C);
        wait_mode = 1'b1; sub_tick = 1'b1;
        @(negedge clk); #2;
        chk("R12 periph gated", {7'd0, periph_tick}, 8'h00);
        count_ticks(64, 1'b1, cnt);
        chk("R12 sub32 runs", 8'(cnt), 8'd2);
        @(negedge clk); wait_mode = 1'b0; #2;
        chk("R12 periph ungated", {7'd0, periph_tick}, 8'h01);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule